// File: doc/BRIEF.md
# SIMT Lane Mask Divergence Controller

This block holds the active lane mask of one warp whose lanes run in lockstep. When a conditional branch splits the lanes, the block does not drop the lanes that disagree. It first runs the taken path with only the lanes whose condition bit is set. It then runs the other path with the complementary lanes. At the reconvergence point it restores the mask that was in force before the branch. Nested branches save their enclosing state on a small mask stack.

The sequencer that drives the block asserts `br_valid` with the per-lane condition bits when it reaches a branch. It pulses `reconv` at the end of each path. It pulses `issue` for every instruction it sends to the lanes. For each issued instruction the block counts the lanes that did useful work and the lane slots that were lost to masking. These two counts measure the cost of divergence.

Top module: `simt_mask_ctrl`

## Requirements
- R1: After reset, all LANES bits of `active_mask` are 1. `on_else`, `cnt_active`, `cnt_wasted` and `stack_ovf` are 0.
- R2: A branch where some active lanes have their condition bit set and others do not pushes the current state. From the next cycle, `active_mask` equals the old mask AND `br_cond`, and `on_else` is 0.
- R3: A `reconv` during the taken path of a divergent branch switches to the other path. From the next cycle, `active_mask` equals the pre-branch mask AND NOT `br_cond`, and `on_else` is 1.
- R4: A `reconv` on a path with no pending alternative pops the stack. From the next cycle, it restores the mask and the `on_else` value that were in force before the matching branch.
- R5: If every active lane has its condition bit set, the mask is unchanged and `on_else` is 0. The next `reconv` pops directly, and the other path is skipped.
- R6: If no active lane has its condition bit set, the mask is unchanged and `on_else` is 1. The next `reconv` pops directly, and the taken path is skipped.
- R7: Branches nest up to DEPTH levels. Each `reconv` unwinds the innermost level first.
- R8: A branch while DEPTH levels are stored sets `stack_ovf`, which stays 1 until reset. That branch leaves the mask, `on_else` and the stack unchanged.
- R9: On each cycle with `issue` high, `cnt_active` increases by the number of 1 bits in the mask of that cycle, and `cnt_wasted` increases by LANES minus that number. Both counters show the new value from the next cycle. With 8 lanes, one full-mask instruction followed by one instruction on each half gives 16 active and 8 wasted.
- R10: A `reconv` with an empty stack has no effect. A `reconv` in the same cycle as `br_valid` is ignored, and the branch takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Branch strobe; `br_cond` is sampled in this cycle |
| br_cond | input | LANES | Per-lane condition result; bit i belongs to lane i |
| reconv | input | 1 | End of the current path |
| issue | input | 1 | One instruction issued under the current mask |
| active_mask | output | LANES | Lanes enabled for the current instruction |
| on_else | output | 1 | 1 while the non-taken path runs |
| cnt_active | output | CNT_W | Accumulated useful lane slots |
| cnt_wasted | output | CNT_W | Accumulated masked-off lane slots |
| stack_ovf | output | 1 | Sticky mask-stack overflow flag |

## Verification
Every result is a register, so the mask, path flag, counters and overflow flag all respond exactly one clock after the strobe that causes them. An `issue` is charged against the mask in effect in its own cycle, not the mask that a simultaneous branch produces. The bench drives inputs on the falling edge, advances its behavioural queue model by one step, and compares every output at the following falling edge. Every comparison therefore falls after the single register stage. Directed sequences cover the two-path example, uniform conditions, nesting to overflow and strobe collisions. A long random run follows.

// File: rtl/simt_mask_ctrl.sv
module simt_mask_ctrl #(
  parameter int LANES = 32,
  parameter int DEPTH = 4,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_valid,
  input  logic [LANES-1:0] br_cond,
  input  logic             reconv,
  input  logic             issue,
  output logic [LANES-1:0] active_mask,
  output logic             on_else,
  output logic [CNT_W-1:0] cnt_active,
  output logic [CNT_W-1:0] cnt_wasted,
  output logic             stack_ovf
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PCW = $clog2(LANES + 1);

  logic [LANES-1:0] sv_mask   [DEPTH];
  logic [LANES-1:0] pend_mask [DEPTH];
  logic             sv_else   [DEPTH];
  logic [SPW-1:0]   sp;

  function automatic logic [PCW-1:0] popcnt(input logic [LANES-1:0] v);
    logic [PCW-1:0] n;
    n = '0;
    for (int i = 0; i < LANES; i++) n = n + PCW'(v[i]);
    return n;
  endfunction

  wire [LANES-1:0] then_m  = active_mask & br_cond;
  wire [LANES-1:0] else_m  = active_mask & ~br_cond;
  wire             full    = (sp == SPW'(DEPTH));
  wire             empty   = (sp == '0);
  wire [IW-1:0]    top     = IW'(sp - SPW'(1));
  wire [IW-1:0]    nxt     = IW'(sp);
  wire             do_push = br_valid && !full;
  wire             do_rc   = reconv && !br_valid && !empty;
  wire [PCW-1:0]   n_on    = popcnt(active_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_mask <= '1;
      on_else     <= 1'b0;
      sp          <= '0;
      cnt_active  <= '0;
      cnt_wasted  <= '0;
      stack_ovf   <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        sv_mask[i]   <= '0;
        pend_mask[i] <= '0;
        sv_else[i]   <= 1'b0;
      end
    end else begin
      if (br_valid && full) stack_ovf <= 1'b1;
      if (do_push) begin
        sv_mask[nxt] <= active_mask;
        sv_else[nxt] <= on_else;
        sp           <= sp + SPW'(1);
        if (then_m != '0) begin
          active_mask    <= then_m;
          on_else        <= 1'b0;
          pend_mask[nxt] <= else_m;
        end else begin
          active_mask    <= else_m;
          on_else        <= 1'b1;
          pend_mask[nxt] <= '0;
        end
      end else if (do_rc) begin
        if (pend_mask[top] != '0) begin
          active_mask    <= pend_mask[top];
          on_else        <= 1'b1;
          pend_mask[top] <= '0;
        end else begin
          active_mask <= sv_mask[top];
          on_else     <= sv_else[top];
          sp          <= sp - SPW'(1);
        end
      end
      if (issue) begin
        cnt_active <= cnt_active + CNT_W'(n_on);
        cnt_wasted <= cnt_wasted + CNT_W'(LANES) - CNT_W'(n_on);
      end
    end
  end

  // R2
  branch_narrows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> ((active_mask & ~$past(active_mask)) == '0));

  // R4
  outer_full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (active_mask == '1 && !on_else));

  // R9
  slot_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (cnt_active + cnt_wasted) == ($past(cnt_active) + $past(cnt_wasted) + CNT_W'(LANES)));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_ovf |=> stack_ovf);

  // R8
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && full) |=> ($stable(active_mask) && $stable(on_else)));
endmodule

// File: tb/simt_mask_ctrl_tb.sv
module simt_mask_ctrl_tb;
  localparam int PER = 10;
  localparam int L   = 8;
  localparam int D   = 4;
  localparam int CW  = 32;

  logic clk = 1'b0, rst_n = 1'b0, br_valid = 1'b0, reconv = 1'b0, issue = 1'b0;
  logic [L-1:0] br_cond = '0;
  logic [L-1:0] active_mask;
  logic on_else, stack_ovf;
  logic [CW-1:0] cnt_active, cnt_wasted;

  simt_mask_ctrl #(.LANES(L), .DEPTH(D), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_cond(br_cond),
    .reconv(reconv), .issue(issue), .active_mask(active_mask), .on_else(on_else),
    .cnt_active(cnt_active), .cnt_wasted(cnt_wasted), .stack_ovf(stack_ovf));

  always #(PER/2) clk = ~clk;

  int vecs = 0, errs = 0;
  logic [L-1:0] m_mask = '1;
  bit m_else = 0, m_ovf = 0;
  longint m_act = 0, m_waste = 0;
  logic [L-1:0] q_saved[$], q_pend[$];
  bit q_else[$];
  string tag = "R1";

  task automatic chk(string r, string what, longint act, longint exp);
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic compare();
    vecs++;
    chk(tag, "mask", active_mask, m_mask);
    chk(tag, "path", on_else, m_else);
    chk("R9", "active count", cnt_active, m_act);
    chk("R9", "wasted count", cnt_wasted, m_waste);
    chk("R8", "overflow", stack_ovf, m_ovf);
  endtask

  task automatic step(bit br, logic [L-1:0] c, bit rc, bit iss);
    logic [L-1:0] t, e;
    int pc;
    br_valid = br; br_cond = c; reconv = rc; issue = iss;
    if (iss) begin
      pc = $countones(m_mask);
      m_act += pc;
      m_waste += L - pc;
    end
    if (br) begin
      if (q_saved.size() == D) begin
        m_ovf = 1; tag = "R8";
      end else begin
        t = m_mask & c; e = m_mask & ~c;
        q_saved.push_back(m_mask); q_else.push_back(m_else);
        if (q_saved.size() > 1) tag = "R7";
        else if (e == 0) tag = "R5";
        else if (t == 0) tag = "R6";
        else tag = "R2";
        if (t != 0) begin m_mask = t; m_else = 0; q_pend.push_back(e); end
        else begin m_mask = e; m_else = 1; q_pend.push_back('0); end
      end
    end else if (rc) begin
      if (q_saved.size() == 0) tag = "R10";
      else if (q_pend[q_pend.size()-1] != 0) begin
        m_mask = q_pend[q_pend.size()-1]; m_else = 1;
        q_pend[q_pend.size()-1] = '0; tag = "R3";
      end else begin
        m_mask = q_saved.pop_back(); m_else = q_else.pop_back();
        void'(q_pend.pop_back()); tag = "R4";
      end
    end
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(PER*200000);
    errs++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1"; compare();
    rst_n = 1'b1;
    // R9 worked example: full, then half, else half
    step(0, '0, 0, 1);
    step(1, 8'h0F, 0, 0);
    step(0, '0, 0, 1);
    step(0, '0, 1, 0);
    step(0, '0, 0, 1);
    step(0, '0, 1, 0);
    vecs++;
    chk("R9", "example active", cnt_active, 16);
    chk("R9", "example wasted", cnt_wasted, 8);
    // R5 and R6 uniform conditions
    step(1, 8'hFF, 0, 1); step(0, '0, 0, 1); step(0, '0, 1, 0);
    step(1, 8'h00, 0, 1); step(0, '0, 0, 1); step(0, '0, 1, 0);
    // R10 empty reconv, collision
    step(0, '0, 1, 1);
    step(1, 8'h33, 1, 1);
    // R7 nesting, R8 overflow
    step(1, 8'h0F, 0, 0); step(1, 8'h05, 0, 1); step(1, 8'h01, 0, 1);
    step(1, 8'hAA, 0, 1);
    vecs++;
    chk("R8", "overflow after fifth branch", stack_ovf, 1);
    for (int i = 0; i < 10; i++) step(0, '0, 1, 1);
    // random run
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [L-1:0] c;
      r = $urandom_range(0, 9);
      c = $urandom();
      if ($urandom_range(0, 5) == 0) c = '1;
      if ($urandom_range(0, 5) == 0) c = '0;
      step(r < 2, c, (r >= 2 && r < 5) || r == 9, $urandom_range(0, 1) == 1);
      if (i == 2000) begin
        rst_n = 1'b0; br_valid = 0; reconv = 0; issue = 0;
        @(negedge clk);
        m_mask = '1; m_else = 0; m_ovf = 0; m_act = 0; m_waste = 0;
        q_saved.delete(); q_pend.delete(); q_else.delete();
        tag = "R1"; compare();
        rst_n = 1'b1;
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule